// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the data side of a small accumulator machine. A single 16-bit bus joins a 4096 x 16 word store and seven registers: two 12-bit address-width registers (address and program counter) and five 16-bit registers (data, accumulator, instruction, temporary and output). Exactly one source drives the bus in any cycle. Seven one-hot source-request lines are encoded into a 3-bit select code, and a multiplexer uses that code to pick the source. The request line for the store also acts as the store's read strobe, so the word addressed by the address register appears on the bus.

Each register has clear, load and increment strobes. A register that loads takes the bus value on the rising clock edge. The accumulator is the exception: it loads from a small arithmetic/logic unit whose operands are the accumulator itself and the data register. All strobes come from an external sequencer. This block only carries them out and has no instruction decoding of its own. No data input exists at the edge, so every value must be built inside the datapath.

Top module: `shared_bus_datapath`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, every register output is zero, the select code is 000 and the bus is zero.
- R2: The request bits are src_req[0..6] (sources 1..7). A single asserted request k produces select code k: 001 address, 010 program counter, 011 data, 100 accumulator, 101 instruction, 110 temporary, 111 store. With no request asserted, the select code is 000 and the bus carries all zeros.
- R3: The bus carries the selected source in the same cycle. A 12-bit source appears with bits 15:12 at zero.
- R4: When several requests are asserted at once, the highest-numbered request wins.
- R5: A register whose load strobe is set takes the bus value on the rising edge. A 12-bit register keeps only bits 11:0 of the bus.
- R6: The increment strobe adds one on the rising edge, wrapping modulo the register width (a 12-bit register goes from 0xFFF to 0x000).
- R7: Within one register, clear beats load and load beats increment.
- R8: A write stores the bus value at the word addressed by the address register value from before the edge, even if the address register also loads on that edge. Request 7 places the addressed word on the bus combinationally. A write and request 7 never occur together.
- R9: The accumulator load strobe takes the unit result, never the bus. The 3-bit operation codes are 000 copy data register, 001 AND with data register, 010 add data register modulo 2^16, 011 complement, 100 shift right with zero fill, 101 shift left with zero fill. Codes 110 and 111 leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 7 | One-hot bus source requests, bit k-1 = source k |
| mem_wr | input | 1 | Store bus value at address register |
| reg_ld | input | 7 | Load strobes: 0 addr, 1 pc, 2 data, 3 acc, 4 instr, 5 temp, 6 out |
| reg_inr | input | 7 | Increment strobes, same bit order |
| reg_clr | input | 7 | Clear strobes, same bit order |
| alu_op | input | 3 | Operation for the accumulator load |
| bus_sel | output | 3 | Encoded source select |
| bus_data | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| outr_q | output | 16 | Output register |

## Verification
The hardest situation to reach is a store write on the same edge that the address register reloads from the bus. Checking it needs known, distinct values already sitting in the source registers and in the address register. The block has no data input, so the stimulus builds every value inside the accumulator. It clears the accumulator, then for each bit shifts left and increments where the bit is set, and finally copies the result over the bus into the target register. Once these values are in place, the write-with-reload cycle is run, and the old and new addresses are read back through request 7.

// File: rtl/busdp_pkg.sv
package busdp_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 12;
  localparam int NUM_SRC = 7;
  localparam int SEL_W   = $clog2(NUM_SRC + 1);
  localparam int NUM_REG = 7;

  typedef enum logic [2:0] {
    OP_XFER = 3'b000,
    OP_AND  = 3'b001,
    OP_ADD  = 3'b010,
    OP_CMA  = 3'b011,
    OP_SHR  = 3'b100,
    OP_SHL  = 3'b101
  } alu_op_e;

  localparam int IDX_AR   = 0;
  localparam int IDX_PC   = 1;
  localparam int IDX_DR   = 2;
  localparam int IDX_AC   = 3;
  localparam int IDX_IR   = 4;
  localparam int IDX_TR   = 5;
  localparam int IDX_OUTR = 6;
endpackage

// File: rtl/bus_sel_encoder.sv
module bus_sel_encoder #(
  parameter int N_REQ = 7,
  parameter int SEL_W = 3
) (
  input  logic [N_REQ-1:0] req,
  output logic [SEL_W-1:0] sel
);
  // highest set request wins: later loop iterations overwrite earlier ones
  always_comb begin
    sel = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req[i]) sel = SEL_W'(i + 1);
    end
  end
endmodule

// File: rtl/bus_mux.sv
module bus_mux #(
  parameter int DATA_W = 16,
  parameter int N_SRC  = 7,
  parameter int SEL_W  = 3
) (
  input  logic [N_SRC-1:0][DATA_W-1:0] src,
  input  logic [SEL_W-1:0]             sel,
  output logic [DATA_W-1:0]            bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(i + 1)) bus = src[i];
    end
  end
endmodule

// File: rtl/ctl_register.sv
module ctl_register #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic         inr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= d;
    else if (inr) q <= q + W'(1);
  end
endmodule

// File: rtl/word_memory.sv
module word_memory #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[addr] <= wdata;
  end

  assign rdata = rd_en ? store[addr] : '0;
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import busdp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] dat,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_XFER: res = dat;
      OP_AND:  res = acc & dat;
      OP_ADD:  res = acc + dat;
      OP_CMA:  res = ~acc;
      OP_SHR:  res = {1'b0, acc[W-1:1]};
      OP_SHL:  res = {acc[W-2:0], 1'b0};
      default: res = acc;
    endcase
  end
endmodule

// File: rtl/shared_bus_datapath.sv
module shared_bus_datapath
  import busdp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_req,
  input  logic                 mem_wr,
  input  logic [NUM_REG-1:0]   reg_ld,
  input  logic [NUM_REG-1:0]   reg_inr,
  input  logic [NUM_REG-1:0]   reg_clr,
  input  logic [2:0]           alu_op,
  output logic [SEL_W-1:0]     bus_sel,
  output logic [DATA_W-1:0]    bus_data,
  output logic [ADDR_W-1:0]    ar_q,
  output logic [ADDR_W-1:0]    pc_q,
  output logic [DATA_W-1:0]    dr_q,
  output logic [DATA_W-1:0]    ac_q,
  output logic [DATA_W-1:0]    ir_q,
  output logic [DATA_W-1:0]    tr_q,
  output logic [DATA_W-1:0]    outr_q
);
  localparam int PAD_W  = DATA_W - ADDR_W;
  localparam int N_ADDR = 2;
  localparam int N_DATA = 4;
  localparam int ADDR_IDX [N_ADDR] = '{IDX_AR, IDX_PC};
  localparam int DATA_IDX [N_DATA] = '{IDX_DR, IDX_IR, IDX_TR, IDX_OUTR};

  logic [N_ADDR-1:0][ADDR_W-1:0]  addr_q;
  logic [N_DATA-1:0][DATA_W-1:0]  data_q;
  logic [NUM_SRC-1:0][DATA_W-1:0] src_vals;
  logic [DATA_W-1:0]              mem_rdata;
  logic [DATA_W-1:0]              alu_res;
  logic                           mem_rd;

  // the store's request line doubles as its read strobe
  assign mem_rd = src_req[NUM_SRC-1];

  bus_sel_encoder #(.N_REQ(NUM_SRC), .SEL_W(SEL_W)) u_enc (
    .req (src_req),
    .sel (bus_sel)
  );

  generate
    for (genvar g = 0; g < N_ADDR; g++) begin : g_addr_reg
      ctl_register #(.W(ADDR_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reg_clr[ADDR_IDX[g]]),
        .ld    (reg_ld[ADDR_IDX[g]]),
        .inr   (reg_inr[ADDR_IDX[g]]),
        .d     (bus_data[ADDR_W-1:0]),
        .q     (addr_q[g])
      );
    end
    for (genvar g = 0; g < N_DATA; g++) begin : g_data_reg
      ctl_register #(.W(DATA_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reg_clr[DATA_IDX[g]]),
        .ld    (reg_ld[DATA_IDX[g]]),
        .inr   (reg_inr[DATA_IDX[g]]),
        .d     (bus_data),
        .q     (data_q[g])
      );
    end
  endgenerate

  alu_unit #(.W(DATA_W)) u_alu (
    .op  (alu_op),
    .acc (ac_q),
    .dat (dr_q),
    .res (alu_res)
  );

  ctl_register #(.W(DATA_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (reg_clr[IDX_AC]),
    .ld    (reg_ld[IDX_AC]),
    .inr   (reg_inr[IDX_AC]),
    .d     (alu_res),
    .q     (ac_q)
  );

  word_memory #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .wr_en (mem_wr),
    .rd_en (mem_rd),
    .addr  (ar_q),
    .wdata (bus_data),
    .rdata (mem_rdata)
  );

  assign ar_q   = addr_q[0];
  assign pc_q   = addr_q[1];
  assign dr_q   = data_q[0];
  assign ir_q   = data_q[1];
  assign tr_q   = data_q[2];
  assign outr_q = data_q[3];

  // source order follows select codes 1..7
  assign src_vals[0] = {{PAD_W{1'b0}}, ar_q};
  assign src_vals[1] = {{PAD_W{1'b0}}, pc_q};
  assign src_vals[2] = dr_q;
  assign src_vals[3] = ac_q;
  assign src_vals[4] = ir_q;
  assign src_vals[5] = tr_q;
  assign src_vals[6] = mem_rdata;

  bus_mux #(.DATA_W(DATA_W), .N_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src (src_vals),
    .sel (bus_sel),
    .bus (bus_data)
  );
endmodule

// File: rtl/shared_bus_datapath_chk.sv
module shared_bus_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  req,
  input logic        wr,
  input logic [2:0]  sel,
  input logic [15:0] bus,
  input logic [11:0] ar,
  input logic [11:0] pc,
  input logic [15:0] dr,
  input logic        ar_clr,
  input logic        pc_ld,
  input logic        pc_inr,
  input logic        pc_clr,
  input logic        dr_ld,
  input logic        dr_clr
);
  p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && req[6]));

  p_top_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req[6] |-> sel == 3'b111);

  p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req == 7'b0 |-> (sel == 3'b000 && bus == 16'h0000));

  p_ar_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req == 7'b0000001 |-> bus == {4'h0, ar});

  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ar_clr |=> ar == 12'h000);

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_ld && !dr_clr) |=> dr == $past(bus));

  p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inr && !pc_ld && !pc_clr) |=> pc == $past(pc) + 12'd1);

  // several requests at once are legal but worth noting (R4)
  always @(posedge clk) begin
    if (rst_n && $countones(req) > 1)
      $display("note: %0d bus requests at once, highest wins", $countones(req));
  end
endmodule

bind shared_bus_datapath shared_bus_datapath_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req    (src_req),
  .wr     (mem_wr),
  .sel    (bus_sel),
  .bus    (bus_data),
  .ar     (ar_q),
  .pc     (pc_q),
  .dr     (dr_q),
  .ar_clr (reg_clr[0]),
  .pc_ld  (reg_ld[1]),
  .pc_inr (reg_inr[1]),
  .pc_clr (reg_clr[1]),
  .dr_ld  (reg_ld[2]),
  .dr_clr (reg_clr[2])
);

// File: tb/shared_bus_datapath_bench.sv
module shared_bus_datapath_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  src_req;
  logic        mem_wr;
  logic [6:0]  reg_ld, reg_inr, reg_clr;
  logic [2:0]  alu_op;
  logic [2:0]  bus_sel;
  logic [15:0] bus_data;
  logic [11:0] ar_q, pc_q;
  logic [15:0] dr_q, ac_q, ir_q, tr_q, outr_q;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_bus_datapath u_shared_bus_datapath (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .mem_wr(mem_wr),
    .reg_ld(reg_ld), .reg_inr(reg_inr), .reg_clr(reg_clr), .alu_op(alu_op),
    .bus_sel(bus_sel), .bus_data(bus_data), .ar_q(ar_q), .pc_q(pc_q),
    .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q), .outr_q(outr_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    src_req = '0; mem_wr = 1'b0; reg_ld = '0; reg_inr = '0; reg_clr = '0;
    alu_op = 3'b000;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  // build a value in AC from zero: shift left, increment where bit set
  task automatic set_ac(input logic [15:0] v);
    reg_clr[3] = 1'b1; step();
    for (int i = 15; i >= 0; i--) begin
      reg_ld[3] = 1'b1; alu_op = 3'b101; step();
      if (v[i]) begin reg_inr[3] = 1'b1; step(); end
    end
  endtask

  task automatic load_reg(input int idx, input logic [15:0] v);
    set_ac(v);
    src_req = 7'b0001000; reg_ld[idx] = 1'b1; step();
  endtask

  task automatic t_reset();
    chk("R1", "ar", {4'h0, ar_q}, 16'h0);
    chk("R1", "pc", {4'h0, pc_q}, 16'h0);
    chk("R1", "dr", dr_q, 16'h0);
    chk("R1", "ac", ac_q, 16'h0);
    chk("R1", "ir", ir_q, 16'h0);
    chk("R1", "tr", tr_q, 16'h0);
    chk("R1", "outr", outr_q, 16'h0);
    chk("R1", "sel", {13'h0, bus_sel}, 16'h0);
    chk("R2", "idle bus", bus_data, 16'h0);
  endtask

  task automatic t_loads();
    load_reg(0, 16'h1ABC); chk("R5", "ar low 12 bits", {4'h0, ar_q}, 16'h0ABC);
    load_reg(1, 16'hF123); chk("R5", "pc low 12 bits", {4'h0, pc_q}, 16'h0123);
    load_reg(2, 16'h1234); chk("R5", "dr load", dr_q, 16'h1234);
    load_reg(4, 16'h5A5A); chk("R5", "ir load", ir_q, 16'h5A5A);
    load_reg(5, 16'hBEEF); chk("R5", "tr load", tr_q, 16'hBEEF);
  endtask

  task automatic t_encode();
    logic [15:0] exp_bus [6];
    exp_bus = '{16'h0ABC, 16'h0123, 16'h1234, 16'hBEEF, 16'h5A5A, 16'hBEEF};
    for (int i = 0; i < 7; i++) begin
      src_req = 7'(1 << i); #1;
      chk("R2", "single request code", {13'h0, bus_sel}, 16'(i + 1));
      if (i < 6) chk("R3", "bus value", bus_data, exp_bus[i]);
      step();
    end
  endtask

  task automatic t_priority();
    src_req = 7'b0000101; #1;
    chk("R4", "ar+dr sel", {13'h0, bus_sel}, 16'd3);
    chk("R4", "ar+dr bus", bus_data, 16'h1234);
    step();
    src_req = 7'b0100011; #1;
    chk("R4", "ar+pc+tr sel", {13'h0, bus_sel}, 16'd6);
    chk("R4", "ar+pc+tr bus", bus_data, 16'hBEEF);
    step();
    src_req = 7'b1111111; #1;
    chk("R4", "all requests sel", {13'h0, bus_sel}, 16'd7);
    step();
  endtask

  task automatic t_incr_prio();
    reg_inr[2] = 1'b1; step();
    chk("R6", "dr increment", dr_q, 16'h1235);
    reg_inr[1] = 1'b1; step();
    chk("R6", "pc increment", {4'h0, pc_q}, 16'h0124);
    src_req = 7'b0100000; reg_clr[2] = 1'b1; reg_ld[2] = 1'b1; reg_inr[2] = 1'b1; step();
    chk("R7", "clear beats load", dr_q, 16'h0000);
    src_req = 7'b0100000; reg_ld[2] = 1'b1; reg_inr[2] = 1'b1; step();
    chk("R7", "load beats increment", dr_q, 16'hBEEF);
    load_reg(0, 16'h0FFF);
    reg_inr[0] = 1'b1; step();
    chk("R6", "ar wraps", {4'h0, ar_q}, 16'h0000);
    set_ac(16'hFFFF);
    reg_inr[3] = 1'b1; step();
    chk("R6", "ac wraps", ac_q, 16'h0000);
  endtask

  task automatic t_memory();
    load_reg(0, 16'h0005);
    src_req = 7'b0100000; mem_wr = 1'b1; step();
    load_reg(0, 16'h0007);
    src_req = 7'b0010000; mem_wr = 1'b1; reg_ld[0] = 1'b1; step();
    chk("R8", "ar reloaded during write", {4'h0, ar_q}, 16'h0A5A);
    load_reg(0, 16'h0005);
    src_req = 7'b1000000; reg_ld[6] = 1'b1; #1;
    chk("R8", "read word 5", bus_data, 16'hBEEF);
    step();
    chk("R8", "outr from store", outr_q, 16'hBEEF);
    load_reg(0, 16'h0007);
    src_req = 7'b1000000; #1;
    chk("R8", "write used old address", bus_data, 16'h5A5A);
    step();
  endtask

  task automatic t_alu();
    load_reg(2, 16'h1234);
    set_ac(16'h0F0F);
    reg_ld[3] = 1'b1; alu_op = 3'b001; step();
    chk("R9", "and", ac_q, 16'h0204);
    set_ac(16'h0F0F);
    reg_ld[3] = 1'b1; alu_op = 3'b010; step();
    chk("R9", "add", ac_q, 16'h2143);
    set_ac(16'hFFFF);
    reg_ld[3] = 1'b1; alu_op = 3'b010; step();
    chk("R9", "add wraps", ac_q, 16'h1233);
    reg_ld[3] = 1'b1; alu_op = 3'b011; step();
    chk("R9", "complement", ac_q, 16'hEDCC);
    reg_ld[3] = 1'b1; alu_op = 3'b100; step();
    chk("R9", "shift right", ac_q, 16'h76E6);
    reg_ld[3] = 1'b1; alu_op = 3'b101; step();
    chk("R9", "shift left", ac_q, 16'hEDCC);
    src_req = 7'b0100000; reg_ld[3] = 1'b1; alu_op = 3'b000; step();
    chk("R9", "copy takes dr not bus", ac_q, 16'h1234);
    reg_ld[3] = 1'b1; alu_op = 3'b110; step();
    chk("R9", "code 110 holds", ac_q, 16'h1234);
    reg_ld[3] = 1'b1; alu_op = 3'b111; step();
    chk("R9", "code 111 holds", ac_q, 16'h1234);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_loads();
    t_encode();
    t_priority();
    t_incr_prio();
    t_memory();
    t_alu();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule